// File: doc/BRIEF.md
# Streaming Eight-Tap Array Correlator

This block is a small coprocessor. It takes two arrays, `a` and `b`, of eight unsigned 8-bit elements each. It produces the fifteen sums of products that a full discrete convolution gives when `a` is taken in reverse order against `b`. Result slot `k` (0 to 14) holds the sum over `j` of `a[7-k+j]*b[j]`, counting only the terms whose indices lie in 0..7.

Operand pairs arrive one per cycle over a single 16-bit input port while a load strobe is high. A single-cycle start strobe then launches a run. The block produces one result per clock and presents it on a 32-bit output port together with a one-cycle valid pulse, so results appear while the run is still going rather than after it ends. A busy flag covers the whole run. Start and load requests that arrive during a run are ignored, so the operands stay fixed while they are being read.

Top module: `seqconv_core`

## Requirements
- R1: A synchronous active-low reset, applied even in the middle of a run, clears `dout`, `res_vld` and `busy` to zero, zeroes every stored operand and returns the load position to element 0. A run started after reset with no loads yields fifteen zero results.
- R2: Each cycle with `ld_stb` high while idle stores `din[7:0]` as `a[i]` and `din[15:8]` as `b[i]`. The position `i` counts 0 to 7 and wraps, so a ninth load overwrites element 0.
- R3: Result `k`, for k = 0 to 14 and in that order, equals the sum over j of `a[7-k+j]*b[j]`, where out-of-range terms count as zero. For a = {1,4,5,8,6,9,11,2} and b = {31,25,9,7,16,19,3,2}, the results are hex 3e, 187, 23c, 20c, 24c, 2ae, 2d2, 218, 183, 131, ca, 7b, 29, b, 2.
- R4: If `go_stb` is sampled at clock edge E while idle, result 0 is shown with `res_vld` high after edge E+1. Results 1 to 14 follow on the next fourteen edges, with `res_vld` high on each of those fifteen consecutive cycles.
- R5: `busy` goes high after edge E. It stays high through the cycle that shows result 14 and is low after edge E+16. `res_vld` is never high while `busy` is low.
- R6: A `go_stb` that arrives while `busy` is high is ignored. The run still gives exactly fifteen valid pulses and does not restart.
- R7: A `ld_stb` that arrives while `busy` is high is ignored. Neither the operands nor the load position change.
- R8: Results are kept at full width (19 bits by default) and zero-extended onto `dout[31:0]`. With all operands 0xFF, result 7 is 0x7F008 and `dout[31:19]` is zero.
- R9: While `res_vld` is low, `dout` holds the last result issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 16 | Operand pair: `b` element in [15:8], `a` element in [7:0] |
| ld_stb | input | 1 | Load strobe, stores one operand pair per cycle |
| go_stb | input | 1 | Start strobe, launches a run when idle |
| dout | output | 32 | Current result, zero-extended |
| res_vld | output | 1 | One-cycle pulse per result issued |
| busy | output | 1 | High while a run is in progress |

## Verification
The product sum is exercised with the worked example and with several other operand patterns, each chosen to separate a different fault:
- The worked example catches a wrong sum or a wrong slot order.
- An impulse at the top of `a` copies `b` into slots 0 to 7 in order, which exposes a swapped or mis-indexed `b`.
- An impulse at the bottom of `b` places `a` reversed into those same slots, which exposes a missing reversal.
- All-ones operands drive every slot to its maximum, which shows any truncation of the accumulator.

Further directed cases cover the ninth load overwriting element 0, start and load strobes arriving in the middle of a run, a reset applied during a run, and a run on freshly cleared operands.

// File: rtl/seqconv_pkg.sv
// Shared defaults and width helpers for the array correlator.
// Assumes unsigned operands; widths are derived from tap count and data width.
package seqconv_pkg;
    localparam int CV_TAPS  = 8;
    localparam int CV_DW    = 8;
    localparam int CV_OUT_W = 32;

    // Accumulator width that holds taps * (2^dw - 1)^2 without overflow.
    function automatic int acc_width(input int taps, input int dw);
        return 2 * dw + $clog2(taps);
    endfunction
endpackage

// File: rtl/seqconv_opbank.sv
// Operand bank: holds the a and b arrays, filled one pair per load strobe.
// Assumes loads are refused while a run is active so the operands stay stable.
module seqconv_opbank #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_stb,
    input  logic                  busy,
    input  logic [2*DW-1:0]       din,
    output logic [N-1:0][DW-1:0]  a_vec,
    output logic [N-1:0][DW-1:0]  b_vec
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam logic [PW-1:0] LAST_POS = PW'(N - 1);

    logic [PW-1:0] wr_pos;

    // Store one operand pair per accepted strobe and advance the wrapping position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vec  <= '0;
            b_vec  <= '0;
            wr_pos <= '0;
        end else if (ld_stb && !busy) begin
            a_vec[wr_pos] <= din[DW-1:0];
            b_vec[wr_pos] <= din[2*DW-1:DW];
            wr_pos        <= (wr_pos == LAST_POS) ? '0 : wr_pos + PW'(1);
        end
    end

    // R7
    frozen_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_vec) && $stable(b_vec)));
endmodule

// File: rtl/seqconv_seq.sv
// Run sequencer: starts a run on an idle start strobe, steps the 4-bit slot
// index once per cycle through all result slots, then drops busy one cycle
// after the last slot is issued. Assumes NRES fits in IW bits.
module seqconv_seq #(
    parameter int NRES = 15,
    parameter int IW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_stb,
    output logic          run,
    output logic [IW-1:0] idx,
    output logic          busy
);
    localparam logic [IW-1:0] LAST = IW'(NRES - 1);

    // Start, step and finish the run; start strobes are refused while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            idx  <= '0;
            busy <= 1'b0;
        end else if (go_stb && !busy) begin
            run  <= 1'b1;
            idx  <= '0;
            busy <= 1'b1;
        end else if (run) begin
            if (idx == LAST) run <= 1'b0;
            else             idx <= idx + IW'(1);
        end else if (busy) begin
            busy <= 1'b0;
        end
    end

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (idx <= LAST));

    // R6
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && idx != LAST) |=> (run && idx == $past(idx) + IW'(1)));

    // R5
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> busy);
endmodule

// File: rtl/seqconv_mac.sv
// Product-sum datapath: for the slot index it forms all N products in
// parallel, keeps only the in-range terms, and registers the sum onto the
// output with a valid pulse. Assumes OUT_W > ACC_W.
module seqconv_mac #(
    parameter int N     = 8,
    parameter int DW    = 8,
    parameter int ACC_W = 19,
    parameter int OUT_W = 32,
    parameter int IW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [IW-1:0]         idx,
    input  logic [N-1:0][DW-1:0]  a_vec,
    input  logic [N-1:0][DW-1:0]  b_vec,
    output logic [OUT_W-1:0]      dout,
    output logic                  res_vld
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [ACC_W-1:0] sum_c;
    logic             armed;

    // Sum a[N-1-k+j]*b[j] over the j whose a index falls inside the array.
    always_comb begin
        sum_c = '0;
        for (int j = 0; j < N; j++) begin
            if (j <= int'(idx) && int'(idx) <= N - 1 + j) begin
                sum_c = sum_c
                      + ACC_W'(a_vec[PW'(N - 1 + j - int'(idx))]) * ACC_W'(b_vec[j]);
            end
        end
    end

    // Register the slot result and its valid pulse; hold dout otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            res_vld <= 1'b0;
        end else begin
            res_vld <= issue;
            if (issue) dout <= OUT_W'(sum_c);
        end
    end

    // Marks that one clean cycle has passed since reset, for history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R9
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !res_vld) |-> $stable(dout));

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (dout[OUT_W-1:ACC_W] == '0));
endmodule

// File: rtl/seqconv_core.sv
// Streaming array correlator top: operand bank, run sequencer and
// product-sum datapath. One result per clock during a run.
// Assumes a single clock domain and synchronous active-low reset.
module seqconv_core #(
    parameter int N     = seqconv_pkg::CV_TAPS,
    parameter int DW    = seqconv_pkg::CV_DW,
    parameter int OUT_W = seqconv_pkg::CV_OUT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*DW-1:0]   din,
    input  logic              ld_stb,
    input  logic              go_stb,
    output logic [OUT_W-1:0]  dout,
    output logic              res_vld,
    output logic              busy
);
    localparam int NRES  = 2 * N - 1;
    localparam int IW    = $clog2(NRES);
    localparam int ACC_W = seqconv_pkg::acc_width(N, DW);

    logic [N-1:0][DW-1:0] a_vec;
    logic [N-1:0][DW-1:0] b_vec;
    logic                 run;
    logic [IW-1:0]        idx;

    seqconv_opbank #(.N(N), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .busy(busy),
        .din(din), .a_vec(a_vec), .b_vec(b_vec)
    );

    seqconv_seq #(.NRES(NRES), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_stb(go_stb),
        .run(run), .idx(idx), .busy(busy)
    );

    seqconv_mac #(.N(N), .DW(DW), .ACC_W(ACC_W), .OUT_W(OUT_W), .IW(IW)) u_mac (
        .clk(clk), .rst_n(rst_n), .issue(run), .idx(idx),
        .a_vec(a_vec), .b_vec(b_vec), .dout(dout), .res_vld(res_vld)
    );

    // R5
    vld_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> busy);
endmodule

// File: tb/test_seqconv_core.sv
`timescale 1ns/1ps
module test_seqconv_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] din;
    logic        ld_stb;
    logic        go_stb;
    logic [31:0] dout;
    logic        res_vld;
    logic        busy;

    always #2 clk = ~clk;

    seqconv_core i_seqconv_core (
        .clk(clk), .rst_n(rst_n), .din(din), .ld_stb(ld_stb), .go_stb(go_stb),
        .dout(dout), .res_vld(res_vld), .busy(busy)
    );

    // Stimulus vectors: element i of each array sits in bits [8i+7:8i].
    localparam logic [63:0] VA [4] = '{
        64'h020B_0906_0805_0401,   // worked example a
        64'hFFFF_FFFF_FFFF_FFFF,   // all ones
        64'h0100_0000_0000_0000,   // impulse at a[7]
        64'h0807_0605_0403_0201    // ramp a
    };
    localparam logic [63:0] VB [4] = '{
        64'h0203_1310_0709_191F,   // worked example b
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h0807_0605_0403_0201,   // ramp b
        64'h0000_0000_0000_0001    // impulse at b[0]
    };
    localparam logic [31:0] EX [15] = '{
        32'h3e, 32'h187, 32'h23c, 32'h20c, 32'h24c, 32'h2ae, 32'h2d2, 32'h218,
        32'h183, 32'h131, 32'hca, 32'h7b, 32'h29, 32'hb, 32'h2
    };

    int          n_chk = 0;
    int          n_bad = 0;
    int          vcnt  = 0;
    logic [31:0] got [15];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_res(input logic [63:0] av, input logic [63:0] bv, input int k);
        logic [31:0] s = 0;
        for (int j = 0; j < 8; j++) begin
            int ai = 7 - k + j;
            if (ai >= 0 && ai <= 7) s = s + 32'(av[8*ai +: 8]) * 32'(bv[8*j +: 8]);
        end
        return s;
    endfunction

    // Count valid pulses away from the active edge.
    always @(negedge clk) if (res_vld) vcnt++;

    task automatic load_ops(input logic [63:0] av, input logic [63:0] bv);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ld_stb = 1'b1;
            din    = {bv[8*i +: 8], av[8*i +: 8]};
        end
        @(negedge clk);
        ld_stb = 1'b0;
    endtask

    task automatic run_check(input logic [63:0] av, input logic [63:0] bv, input string req,
                             input bit poke_go, input bit poke_ld);
        vcnt   = 0;
        go_stb = 1'b1;
        @(negedge clk);
        go_stb = 1'b0;
        chk("R5 busy after start", {31'd0, busy}, 32'd1);
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            got[k] = dout;
            chk("R4 valid pulse", {31'd0, res_vld}, 32'd1);
            chk(req, dout, expect_res(av, bv, k));
            go_stb = poke_go && (k == 4);
            ld_stb = poke_ld && (k == 6);
            din    = 16'hFFFF;
        end
        @(negedge clk);
        go_stb = 1'b0;
        ld_stb = 1'b0;
        chk("R5 busy low after run", {31'd0, busy}, 32'd0);
        chk("R4 valid low after run", {31'd0, res_vld}, 32'd0);
        chk("R9 dout holds", dout, expect_res(av, bv, 14));
        repeat (3) @(negedge clk);
        chk("R6 fifteen pulses", 32'(vcnt), 32'd15);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; din = '0; ld_stb = 1'b0; go_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 dout reset", dout, 32'd0);
        chk("R1 vld reset", {31'd0, res_vld}, 32'd0);
        chk("R1 busy reset", {31'd0, busy}, 32'd0);
        run_check(64'd0, 64'd0, "R1 cleared operands", 1'b0, 1'b0);

        // R3 vector table
        for (int v = 0; v < 4; v++) begin
            load_ops(VA[v], VB[v]);
            run_check(VA[v], VB[v], "R3 slot result", 1'b0, 1'b0);
            if (v == 0) for (int k = 0; k < 15; k++) chk("R3 worked example", got[k], EX[k]);
            if (v == 1) begin
                chk("R8 full width peak", got[7], 32'h7F008);
                chk("R8 upper bits zero", {19'd0, got[7][31:19]}, 32'd0);
            end
        end

        // R6 and R7: start and load strobes during a run are ignored
        load_ops(VA[2], VB[2]);
        run_check(VA[2], VB[2], "R6 no restart", 1'b1, 1'b1);
        run_check(VA[2], VB[2], "R7 operands kept", 1'b0, 1'b0);

        // R2: ninth load wraps onto element 0
        load_ops(VA[0], VB[0]);
        @(negedge clk);
        ld_stb = 1'b1;
        din    = 16'h0503;
        @(negedge clk);
        ld_stb = 1'b0;
        run_check({VA[0][63:8], 8'h03}, {VB[0][63:8], 8'h05}, "R2 wrap to element 0", 1'b0, 1'b0);

        // R1: reset in the middle of a run
        go_stb = 1'b1;
        @(negedge clk);
        go_stb = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 busy after mid-run reset", {31'd0, busy}, 32'd0);
        chk("R1 vld after mid-run reset", {31'd0, res_vld}, 32'd0);
        chk("R1 dout after mid-run reset", dout, 32'd0);
        run_check(64'd0, 64'd0, "R1 operands cleared by reset", 1'b0, 1'b0);

        summary();
        $finish;
    end
endmodule